// File: doc/BRIEF.md
# Single-Operand Execution Unit with Condition Flags

This unit carries out the one-operand arithmetic, logic, shift and rotate operations of a 16-bit processor. It also produces the four condition flags that go with each result. The caller presents an operand word, the current flags, a 4-bit operation code and a byte/word select, and pulses `in_valid`. One clock later the unit returns the result, the new flags and a write-back enable. The write-back enable tells the register file or memory stage whether the result should be stored.

The same unit also handles the operations that raise or lower a chosen subset of the flags under a 4-bit mask. Setting all four mask bits gives the set-all and clear-all forms.

In byte mode the operation works on the low half of the word only. The flags are then taken at byte width, and the upper byte of the operand passes through unchanged.

Top module: `unop_exec`

## Requirements
- R1: Outputs are registered with one cycle of latency: values accepted at a rising edge with `in_valid` high appear after that edge with `out_valid` high. A synchronous active-high `rst` clears `out_valid`, `wr_en`, `result` and `flags_out` to zero.
- R2: Operation codes are 0 clear, 1 complement, 2 increment, 3 decrement, 4 negate, 5 test, 6 arithmetic shift right, 7 arithmetic shift left, 8 rotate right, 9 rotate left, 10 byte swap, 11 add carry, 12 subtract carry, 13 sign extend, 14 set flags, 15 clear flags. Flags are packed as {N,Z,V,C} in bits 3..0. `wr_en` is high for every accepted operation except test, set flags and clear flags.
- R3: Clear gives result 0 with flags 0100. Complement gives the inverted operand, with N and Z taken from the result, V=0 and C=1.
- R4: Increment and decrement leave C unchanged. V is set only when increment starts at the most positive value, or when decrement starts at the most negative value.
- R5: Negate gives the twos complement of the operand. C=1 unless the result is zero, and V=1 only when the operand is the most negative value.
- R6: Test returns the operand unchanged as `result`, sets N and Z from it, clears V and C, and does not write back.
- R7: Arithmetic shift right keeps the sign bit. Arithmetic shift left fills with 0. Rotate right and rotate left shift the incoming C into the vacated end. In all four, C takes the bit shifted out and V = N xor C of the new flags.
- R8: Byte swap always works on the whole word, whatever the byte/word select. It exchanges the two bytes, sets N and Z from the low byte of the result, and clears V and C.
- R9: Add carry adds the incoming C, and subtract carry subtracts it. V is set on signed wrap: add carry from the most positive value with C=1, or subtract carry from the most negative value with C=1. C is set when add carry goes from all ones with C=1, or when subtract carry goes from zero with C=1.
- R10: Sign extend writes all ones when the incoming N is 1 and all zeros otherwise. N is kept, Z is the inverse of N, V=0, and C is unchanged.
- R11: Set flags returns the incoming flags OR `cc_mask`. Clear flags returns the incoming flags AND NOT `cc_mask`. Both return `result`=0 and do not write back.
- R12: With `byte_mode` high, every operation except byte swap and the two flag operations acts on bits 7..0. N, Z, V and C are computed at 8-bit width, and `result[15:8]` equals `operand[15:8]`.
- R13: A cycle with `in_valid` low gives `out_valid`=0 and `wr_en`=0 after the edge, and leaves `result` and `flags_out` holding their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code (see R2) |
| byte_mode | input | 1 | 1 = operate on the low byte |
| operand | input | 16 | Source word |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| cc_mask | input | 4 | Flag subset for set/clear operations |
| out_valid | output | 1 | Registered result is fresh |
| result | output | 16 | Registered result word |
| flags_out | output | 4 | Registered new flags {N,Z,V,C} |
| wr_en | output | 1 | Registered write-back enable |

## Verification
The bench goes after the signed boundaries where overflow must appear or stay clear:
- increment at 7FFF
- decrement and negate at 8000
- add and subtract carry at FFFF and 0
- the byte-mode equivalents at 7F, 80 and FF

A design that took V from a carry-out, or that looked at bit 15 in byte mode, would report the wrong V or N on exactly these words.

Rotates are run with both values of the incoming carry, because a rotate that ignores C still matches a shift half of the time. Byte swap is checked in byte mode to catch a design that applies the byte select to it. Test and the flag operations are checked for a low write enable, since a spurious write there would corrupt the destination while the flags still looked right.

// File: rtl/unop_pkg.sv
package unop_pkg;

  typedef enum logic [3:0] {
    OP_CLR   = 4'd0,
    OP_COM   = 4'd1,
    OP_INC   = 4'd2,
    OP_DEC   = 4'd3,
    OP_NEG   = 4'd4,
    OP_TST   = 4'd5,
    OP_ASR   = 4'd6,
    OP_ASL   = 4'd7,
    OP_ROR   = 4'd8,
    OP_ROL   = 4'd9,
    OP_SWAB  = 4'd10,
    OP_ADC   = 4'd11,
    OP_SBC   = 4'd12,
    OP_SXT   = 4'd13,
    OP_CCSET = 4'd14,
    OP_CCCLR = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic is_shift(op_e o);
    return (o == OP_ASR) || (o == OP_ASL) || (o == OP_ROR) || (o == OP_ROL);
  endfunction

  function automatic logic is_ccop(op_e o);
    return (o == OP_CCSET) || (o == OP_CCCLR);
  endfunction

endpackage

// File: rtl/unop_arith.sv
module unop_arith
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] x,
  input  logic         cin,
  input  logic         nin,
  output logic [W-1:0] r,
  output logic         v,
  output logic         c
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cin_w;
  assign cin_w = {{(W-1){1'b0}}, cin};

  always_comb begin
    r = x;
    v = 1'b0;
    c = cin;
    unique case (op)
      OP_CLR: begin
        r = ZERO;
        c = 1'b0;
      end
      OP_COM: begin
        r = ~x;
        c = 1'b1;
      end
      OP_INC: begin
        r = x + ONE;
        v = (x == MAXP);
      end
      OP_DEC: begin
        r = x - ONE;
        v = (x == MINN);
      end
      OP_NEG: begin
        r = ZERO - x;
        v = (x == MINN);
        c = (x != ZERO);
      end
      OP_TST: begin
        r = x;
        c = 1'b0;
      end
      OP_ADC: begin
        r = x + cin_w;
        v = cin && (x == MAXP);
        c = cin && (x == ONES);
      end
      OP_SBC: begin
        r = x - cin_w;
        v = cin && (x == MINN);
        c = cin && (x == ZERO);
      end
      OP_SXT: begin
        r = {W{nin}};
      end
      default: begin
        r = x;
      end
    endcase
  end
endmodule

// File: rtl/unop_shift.sv
module unop_shift
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] x,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         c
);
  always_comb begin
    r = x;
    c = cin;
    unique case (op)
      OP_ASR: begin
        r = {x[W-1], x[W-1:1]};
        c = x[0];
      end
      OP_ASL: begin
        r = {x[W-2:0], 1'b0};
        c = x[W-1];
      end
      OP_ROR: begin
        r = {cin, x[W-1:1]};
        c = x[0];
      end
      OP_ROL: begin
        r = {x[W-2:0], cin};
        c = x[W-1];
      end
      default: begin
        r = x;
        c = cin;
      end
    endcase
  end
endmodule

// File: rtl/unop_lane.sv
module unop_lane
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] x,
  input  flags_t       fin,
  output logic [W-1:0] r,
  output flags_t       fo
);
  logic [W-1:0] ar, sr;
  logic         av, ac, sc;
  logic         sh;

  unop_arith #(.W(W)) u_arith (
    .op (op),
    .x  (x),
    .cin(fin.c),
    .nin(fin.n),
    .r  (ar),
    .v  (av),
    .c  (ac)
  );

  unop_shift #(.W(W)) u_shift (
    .op (op),
    .x  (x),
    .cin(fin.c),
    .r  (sr),
    .c  (sc)
  );

  assign sh = is_shift(op);

  always_comb begin
    r    = sh ? sr : ar;
    fo.n = r[W-1];
    fo.z = (r == '0);
    fo.c = sh ? sc : ac;
    fo.v = sh ? (fo.n ^ fo.c) : av;
  end
endmodule

// File: rtl/unop_ccop.sv
module unop_ccop
  import unop_pkg::*;
(
  input  op_e    op,
  input  flags_t fin,
  input  flags_t mask,
  output flags_t fo
);
  always_comb begin
    unique case (op)
      OP_CCSET: fo = fin | mask;
      OP_CCCLR: fo = fin & ~mask;
      default:  fo = fin;
    endcase
  end
endmodule

// File: rtl/unop_exec.sv
module unop_exec
  import unop_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic             byte_mode,
  input  logic [WIDTH-1:0] operand,
  input  logic [3:0]       flags_in,
  input  logic [3:0]       cc_mask,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic             wr_en
);
  localparam int HW    = WIDTH / 2;
  localparam int NLANE = 2;

  op_e    op_q;
  flags_t fin;
  flags_t cc_f;
  flags_t sw_f;
  flags_t nxt_f;
  logic [WIDTH-1:0] nxt_r;
  logic [WIDTH-1:0] sw_r;
  logic             nxt_wr;

  logic [WIDTH-1:0] lane_r [NLANE];
  flags_t           lane_f [NLANE];

  assign op_q = op_e'(op);
  assign fin  = flags_t'(flags_in);

  // lane 0 works at full width, lane 1 at half width
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = WIDTH >> g;
    logic [LW-1:0] lr;
    flags_t        lf;
    unop_lane #(.W(LW)) u_lane (
      .op (op_q),
      .x  (operand[LW-1:0]),
      .fin(fin),
      .r  (lr),
      .fo (lf)
    );
    assign lane_r[g] = WIDTH'(lr);
    assign lane_f[g] = lf;
  end

  unop_ccop u_ccop (
    .op  (op_q),
    .fin (fin),
    .mask(flags_t'(cc_mask)),
    .fo  (cc_f)
  );

  // byte swap: whole word, flags from the new low byte
  always_comb begin
    sw_r   = {operand[HW-1:0], operand[WIDTH-1:HW]};
    sw_f.n = sw_r[HW-1];
    sw_f.z = (sw_r[HW-1:0] == '0);
    sw_f.v = 1'b0;
    sw_f.c = 1'b0;
  end

  always_comb begin
    nxt_wr = 1'b1;
    if (is_ccop(op_q)) begin
      nxt_r  = '0;
      nxt_f  = cc_f;
      nxt_wr = 1'b0;
    end else if (op_q == OP_SWAB) begin
      nxt_r = sw_r;
      nxt_f = sw_f;
    end else if (byte_mode) begin
      nxt_r = {operand[WIDTH-1:HW], lane_r[1][HW-1:0]};
      nxt_f = lane_f[1];
    end else begin
      nxt_r = lane_r[0];
      nxt_f = lane_f[0];
    end
    if (op_q == OP_TST) nxt_wr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && nxt_wr;
      if (in_valid) begin
        result    <= nxt_r;
        flags_out <= nxt_f;
      end
    end
  end
endmodule

// File: rtl/unop_exec_chk.sv
module unop_exec_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       op,
  input logic             byte_mode,
  input logic [WIDTH-1:0] operand,
  input logic [3:0]       flags_in,
  input logic [3:0]       cc_mask,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags_out,
  input logic             wr_en
);
  localparam int HW = WIDTH / 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && result == '0 && flags_out == 4'b0000));

  a_r2_wr_needs_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);

  a_r3_clr_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0) |=> (flags_out == 4'b0100 && wr_en));

  a_r4_keep_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd2 || op == 4'd3)) |=> (flags_out[0] == $past(flags_in[0])));

  a_r6_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd5) |=> (!wr_en && flags_out[1:0] == 2'b00));

  a_r7_shift_v_rule: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd6 && op <= 4'd9) |=> (flags_out[1] == (flags_out[3] ^ flags_out[0])));

  a_r11_cc_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd14) |=> (!wr_en && result == '0));

  a_r11_ccset_or: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd14) |=> (flags_out == ($past(flags_in) | $past(cc_mask))));

  a_r12_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_mode && op <= 4'd13 && op != 4'd10)
      |=> (result[WIDTH-1:HW] == $past(operand[WIDTH-1:HW])));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && $stable(result) && $stable(flags_out)));
endmodule

bind unop_exec unop_exec_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .byte_mode(byte_mode),
  .operand  (operand),
  .flags_in (flags_in),
  .cc_mask  (cc_mask),
  .out_valid(out_valid),
  .result   (result),
  .flags_out(flags_out),
  .wr_en    (wr_en)
);

// File: tb/sim_unop_exec.sv
module sim_unop_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] operand = '0;
  logic [3:0]  flags_in = '0;
  logic [3:0]  cc_mask = '0;
  logic        out_valid;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic        wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  unop_exec #(.WIDTH(16)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
    .operand(operand), .flags_in(flags_in), .cc_mask(cc_mask),
    .out_valid(out_valid), .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  // reference: {wr, result[15:0], N, Z, V, C}
  function automatic logic [20:0] model(int o, bit bm, logic [15:0] x, logic [3:0] f, logic [3:0] m);
    int w   = bm ? 8 : 16;
    int msk = (1 << w) - 1;
    int sb  = 1 << (w - 1);
    int v   = int'(x) & msk;
    int ci  = f[0] ? 1 : 0;
    int r   = v;
    bit n, z, vv, c, wr;
    logic [15:0] res;
    c = f[0]; vv = 1'b0; wr = 1'b1;
    case (o)
      0:  begin r = 0; c = 1'b0; end
      1:  begin r = ~v & msk; c = 1'b1; end
      2:  begin r = (v + 1) & msk; vv = (v == sb - 1); end
      3:  begin r = (v - 1) & msk; vv = (v == sb); end
      4:  begin r = (-v) & msk; vv = (v == sb); c = (v != 0); end
      5:  begin r = v; c = 1'b0; wr = 1'b0; end
      6:  begin r = (v >> 1) | (v & sb); c = ((v & 1) != 0); end
      7:  begin r = (v << 1) & msk; c = ((v & sb) != 0); end
      8:  begin r = (v >> 1) | (ci != 0 ? sb : 0); c = ((v & 1) != 0); end
      9:  begin r = ((v << 1) & msk) | ci; c = ((v & sb) != 0); end
      11: begin r = (v + ci) & msk; vv = (ci == 1) && (v == sb - 1); c = (ci == 1) && (v == msk); end
      12: begin r = (v - ci) & msk; vv = (ci == 1) && (v == sb); c = (ci == 1) && (v == 0); end
      13: begin r = f[3] ? msk : 0; end
      default: r = v;
    endcase
    n = ((r & sb) != 0);
    z = (r == 0);
    if (o >= 6 && o <= 9) vv = n ^ c;
    res = bm ? {x[15:8], 8'(r)} : 16'(r);
    if (o == 10) begin
      res = {x[7:0], x[15:8]};
      n = res[7]; z = (res[7:0] == 8'h00); vv = 1'b0; c = 1'b0; wr = 1'b1;
    end
    if (o == 14) begin res = '0; wr = 1'b0; {n, z, vv, c} = f | m; end
    if (o == 15) begin res = '0; wr = 1'b0; {n, z, vv, c} = f & ~m; end
    return {wr, res, n, z, vv, c};
  endfunction

  function automatic string tag_of(int o, bit bm);
    string t;
    case (o)
      0, 1:       t = "R3";
      2, 3:       t = "R4";
      4:          t = "R5";
      5:          t = "R6";
      6, 7, 8, 9: t = "R7";
      10:         t = "R8";
      11, 12:     t = "R9";
      13:         t = "R10";
      default:    t = "R11";
    endcase
    if (bm && o <= 13 && o != 10) t = {t, "/R12"};
    return t;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at the falling edge, sample at the next falling edge (one register on the way)
  task automatic run(int o, bit bm, logic [15:0] x, logic [3:0] f, logic [3:0] m);
    logic [20:0] e;
    string t;
    e = model(o, bm, x, f, m);
    t = tag_of(o, bm);
    in_valid = 1'b1; op = 4'(o); byte_mode = bm; operand = x; flags_in = f; cc_mask = m;
    @(negedge clk);
    check(out_valid == 1'b1, "R1", "out_valid", 32'(out_valid), 32'd1);
    check(result == e[19:4], t, "result", 32'(result), 32'(e[19:4]));
    check(flags_out == e[3:0], t, "flags", 32'(flags_out), 32'(e[3:0]));
    check(wr_en == e[20], "R2", "wr_en", 32'(wr_en), 32'(e[20]));
  endtask

  task automatic idle_step();
    logic [15:0] r0;
    logic [3:0]  f0;
    r0 = result; f0 = flags_out;
    in_valid = 1'b0; operand = 16'($urandom); op = 4'($urandom); flags_in = 4'($urandom);
    @(negedge clk);
    check(!out_valid && !wr_en, "R13", "idle valid/wr", {30'd0, out_valid, wr_en}, 32'd0);
    check(result == r0 && flags_out == f0, "R13", "idle hold", {12'd0, result, flags_out}, {12'd0, r0, f0});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && !wr_en && result == 16'd0 && flags_out == 4'd0, "R1", "reset state",
          {11'd0, out_valid, wr_en, result, flags_out}, 32'd0);
    rst = 1'b0;

    // directed corners
    run(0, 0, 16'h1234, 4'b1011, 4'h0);
    run(1, 0, 16'h00FF, 4'b0000, 4'h0);
    run(2, 0, 16'h7FFF, 4'b0001, 4'h0);
    run(2, 1, 16'hAB7F, 4'b0000, 4'h0);
    run(3, 0, 16'h8000, 4'b0000, 4'h0);
    run(3, 1, 16'h5580, 4'b0001, 4'h0);
    run(4, 0, 16'h8000, 4'b0000, 4'h0);
    run(4, 0, 16'h0000, 4'b0001, 4'h0);
    run(4, 1, 16'h1280, 4'b0000, 4'h0);
    run(5, 0, 16'h8001, 4'b0011, 4'h0);
    run(5, 1, 16'hFF00, 4'b1111, 4'h0);
    run(6, 0, 16'h8001, 4'b0000, 4'h0);
    run(7, 0, 16'h4000, 4'b0000, 4'h0);
    run(7, 1, 16'h3380, 4'b0000, 4'h0);
    run(8, 0, 16'h0002, 4'b0001, 4'h0);
    run(8, 0, 16'h0002, 4'b0000, 4'h0);
    run(9, 0, 16'h8000, 4'b0001, 4'h0);
    run(9, 1, 16'h1280, 4'b0000, 4'h0);
    run(10, 0, 16'h00FF, 4'b1111, 4'h0);
    run(10, 1, 16'h80FF, 4'b0000, 4'h0);
    run(11, 0, 16'hFFFF, 4'b0001, 4'h0);
    run(11, 0, 16'h7FFF, 4'b0001, 4'h0);
    run(11, 1, 16'h00FF, 4'b0001, 4'h0);
    run(12, 0, 16'h0000, 4'b0001, 4'h0);
    run(12, 0, 16'h8000, 4'b0001, 4'h0);
    run(12, 1, 16'h7780, 4'b0001, 4'h0);
    run(13, 0, 16'h1234, 4'b1001, 4'h0);
    run(13, 0, 16'h1234, 4'b0110, 4'h0);
    run(13, 1, 16'hA500, 4'b1000, 4'h0);
    run(14, 0, 16'hFFFF, 4'b0100, 4'b1011);
    run(15, 0, 16'hFFFF, 4'b1111, 4'b0110);
    run(15, 1, 16'h1234, 4'b1111, 4'b1111);
    idle_step();
    idle_step();

    // constrained random: favour boundary words
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x;
      case ($urandom_range(0, 5))
        0: x = 16'h7FFF;
        1: x = 16'h8000;
        2: x = {8'($urandom), 8'h7F + 8'($urandom_range(0, 1))};
        3: x = $urandom_range(0, 1) != 0 ? 16'hFFFF : 16'h0000;
        default: x = 16'($urandom);
      endcase
      run(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), x, 4'($urandom), 4'($urandom));
      if ($urandom_range(0, 15) == 0) idle_step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule